// File: doc/BRIEF.md
# Interrupt Status Register with Per-Bit Set and Clear Rules

This block collects event indications from the parts of a telecom line controller and presents them to a microprocessor as one status byte and one interrupt request line. Each bit follows its own rule. Most bits latch a one-cycle event pulse and stay set until the status byte is read. One bit follows the occupancy of a signaling queue and ignores reads. One bit latches every change of a synchronisation flag. One bit latches an input-pair mismatch and then refuses further mismatch events until a separate detail read releases it.

The processor reads the status byte by pulsing `rd_stb` for one cycle. During that cycle `rd_data` shows the contents as they were before the read, and the clears apply at the next clock edge. An event that arrives in the same cycle as the read is applied after the clear, so the event is not lost. The number of generic sticky sources is a parameter. These generic bits sit at the bottom of the byte.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, every status bit and `irq` are 0.
- R2: Bit layout (default 8 bits, MSB first): timer, queue level, command done, monitor found, sync change, pair mismatch, generic source 1, generic source 0.
- R3: A pulse on `tick_evt`, `cmd_done_evt`, `mon_evt` or a `gen_evt` bit sets its status bit at the next clock edge. The bit then stays set while no read occurs.
- R4: A read pulse clears the timer, command, monitor, sync, mismatch and generic bits at the next edge. `rd_data` during the read cycle shows the contents before the clear.
- R5: An event that coincides with a read pulse leaves its bit set after that edge.
- R6: The queue bit equals `sigq_nonempty` as sampled at the previous clock edge. A read has no effect on it.
- R7: Every change of `sync_state` in either direction sets the sync bit one edge later. Before the first edge after reset, the reference level is `SYNC_INIT`.
- R8: An accepted `miss_evt` sets the mismatch bit and locks the source. While the source is locked, further `miss_evt` pulses are ignored, even after a status read has cleared the bit.
- R9: A `detail_rd` pulse releases the lock from the next cycle on. A `miss_evt` in the same cycle as the releasing `detail_rd` is still ignored.
- R10: `irq` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle status read pulse |
| tick_evt | input | 1 | Timer expiry pulse |
| sigq_nonempty | input | 1 | Signaling queue holds at least one entry (level) |
| cmd_done_evt | input | 1 | Command-finished pulse |
| mon_evt | input | 1 | Active monitor channel found pulse |
| sync_state | input | 1 | Synchronisation status level |
| miss_evt | input | 1 | Input-pair mismatch pulse |
| detail_rd | input | 1 | Mismatch detail register read pulse |
| gen_evt | input | N_GEN | Generic sticky event pulses |
| rd_data | output | N_GEN+6 | Status contents |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The bench goes after a read and an event in the same cycle. A design that applied the clear after the set would silently lose that event. It also reads while the queue level is high, which catches a queue bit wrongly given clear-on-read. It drives the lockout sequence: a status read between two mismatches, then a mismatch together with the detail read. A design that let the status read or the coincident detail read release the lock would raise the mismatch bit too early. A sweep over all 1024 combinations of the ten inputs covers toggles of the sync flag in both directions and the pre-clear value returned during a read.

// File: rtl/irqsr_pkg.sv
package irqsr_pkg;

   typedef enum logic [1:0] {
      CK_STICKY = 2'd0,
      CK_LEVEL  = 2'd1
   } cell_kind_e;

   function automatic cell_kind_e kind_at(input int unsigned idx, input int unsigned level_pos);
      return (idx == level_pos) ? CK_LEVEL : CK_STICKY;
   endfunction

endpackage

// File: rtl/irqsr_sticky_flag.sv
module irqsr_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/irqsr_level_flag.sv
module irqsr_level_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= lvl_i;
   end
endmodule

// File: rtl/irqsr_change_det.sv
module irqsr_change_det #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic chg_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= INIT;
      else        prev_q <= lvl_i;
   end

   assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/irqsr_lock_gate.sv
module irqsr_lock_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic release_i,
   output logic pass_o
);
   logic locked_q;

   assign pass_o = evt_i & ~locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) locked_q <= 1'b0;
      else        locked_q <= (locked_q & ~release_i) | pass_o;
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned N_GEN     = 2,
   parameter bit          SYNC_INIT = 1'b0,
   localparam int unsigned W        = N_GEN + 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             tick_evt,
   input  logic             sigq_nonempty,
   input  logic             cmd_done_evt,
   input  logic             mon_evt,
   input  logic             sync_state,
   input  logic             miss_evt,
   input  logic             detail_rd,
   input  logic [N_GEN-1:0] gen_evt,
   output logic [W-1:0]     rd_data,
   output logic             irq
);
   import irqsr_pkg::*;

   localparam int unsigned P_TMR  = W - 1;
   localparam int unsigned P_SQ   = W - 2;
   localparam int unsigned P_CMD  = W - 3;
   localparam int unsigned P_MON  = W - 4;
   localparam int unsigned P_SYNC = W - 5;
   localparam int unsigned P_MISS = W - 6;

   generate
      if (N_GEN < 1 || N_GEN > 24) begin : g_bad_ngen
         $error("irq_status_reg: N_GEN must lie in 1..24");
      end
   endgenerate

   logic         sync_chg;
   logic         miss_pass;
   logic [W-1:0] set_v;
   logic [W-1:0] q_v;

   irqsr_change_det #(.INIT(SYNC_INIT)) u_sync_det (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (sync_state),
      .chg_o (sync_chg)
   );

   irqsr_lock_gate u_miss_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (miss_evt),
      .release_i (detail_rd),
      .pass_o    (miss_pass)
   );

   always_comb begin
      set_v              = '0;
      set_v[P_TMR]       = tick_evt;
      set_v[P_SQ]        = sigq_nonempty;
      set_v[P_CMD]       = cmd_done_evt;
      set_v[P_MON]       = mon_evt;
      set_v[P_SYNC]      = sync_chg;
      set_v[P_MISS]      = miss_pass;
      set_v[N_GEN-1:0]   = gen_evt;
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         if (kind_at(b, P_SQ) == CK_LEVEL) begin : g_level
            irqsr_level_flag u_flag (
               .clk   (clk),
               .rst_n (rst_n),
               .lvl_i (set_v[b]),
               .q_o   (q_v[b])
            );
         end else begin : g_sticky
            irqsr_sticky_flag u_flag (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_v[b]),
               .clr_i (rd_stb),
               .q_o   (q_v[b])
            );
         end
      end
   endgenerate

   assign rd_data = q_v;
   assign irq     = |q_v;

endmodule

// File: rtl/irqsr_chk.sv
module irqsr_chk #(
   parameter int unsigned N_GEN = 2,
   localparam int unsigned W    = N_GEN + 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_stb,
   input logic             tick_evt,
   input logic             sigq_nonempty,
   input logic             cmd_done_evt,
   input logic             mon_evt,
   input logic             sync_state,
   input logic             miss_evt,
   input logic             detail_rd,
   input logic [N_GEN-1:0] gen_evt,
   input logic [W-1:0]     rd_data,
   input logic             irq
);
   // R3
   tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_evt |=> rd_data[W-1]);

   // R4
   cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !cmd_done_evt) |=> !rd_data[W-3]);

   // R5
   rd_evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mon_evt) |=> rd_data[W-4]);

   // R6
   queue_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rd_data[W-2] == $past(sigq_nonempty)));

   // R7
   sync_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (sync_state != $past(sync_state))) |=> rd_data[W-5]);

   // R8
   miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[W-6] && !rd_stb) |=> rd_data[W-6]);

   // R10
   irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (rd_data != '0));

   // R3
   gen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_evt[0] |=> rd_data[0]);
endmodule

bind irq_status_reg irqsr_chk #(.N_GEN(N_GEN)) u_irqsr_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_stb        (rd_stb),
   .tick_evt      (tick_evt),
   .sigq_nonempty (sigq_nonempty),
   .cmd_done_evt  (cmd_done_evt),
   .mon_evt       (mon_evt),
   .sync_state    (sync_state),
   .miss_evt      (miss_evt),
   .detail_rd     (detail_rd),
   .gen_evt       (gen_evt),
   .rd_data       (rd_data),
   .irq           (irq)
);

// File: tb/test_irq_status_reg.sv
module test_irq_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb = 1'b0, tick_evt = 1'b0, sigq_nonempty = 1'b0, cmd_done_evt = 1'b0;
   logic       mon_evt = 1'b0, sync_state = 1'b0, miss_evt = 1'b0, detail_rd = 1'b0;
   logic [1:0] gen_evt = 2'b00;
   logic [7:0] rd_data;
   logic       irq;

   int   nchk = 0;
   int   nerr = 0;
   bit   done = 1'b0;

   logic [7:0] exp_q  = 8'h00;
   logic       e_prev = 1'b0;
   logic       e_lock = 1'b0;

   always #5 clk = ~clk;

   irq_status_reg #(.N_GEN(2), .SYNC_INIT(1'b0)) i_irq_status_reg (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .tick_evt(tick_evt),
      .sigq_nonempty(sigq_nonempty), .cmd_done_evt(cmd_done_evt), .mon_evt(mon_evt),
      .sync_state(sync_state), .miss_evt(miss_evt), .detail_rd(detail_rd),
      .gen_evt(gen_evt), .rd_data(rd_data), .irq(irq)
   );

   function automatic string tag_of(input int b);
      case (b)
         6:       return "R6";
         3:       return "R7";
         2:       return "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic cmp8(input string tag, input logic [7:0] got, input logic [7:0] want);
      nchk++;
      if (got !== want) begin
         nerr++;
         $display("FAIL %s: rd_data got %02h expected %02h", tag, got, want);
      end
   endtask

   task automatic cmp1(input string tag, input logic got, input logic want);
      nchk++;
      if (got !== want) begin
         nerr++;
         $display("FAIL %s: got %0b expected %0b", tag, got, want);
      end
   endtask

   // v: 0 rd, 1 tick, 2 cmd, 3 mon, 4 gen0, 5 gen1, 6 queue level, 7 sync, 8 miss, 9 detail read
   task automatic step(input logic [9:0] v);
      logic [7:0] nx;
      logic       acc;
      rd_stb = v[0]; tick_evt = v[1]; cmd_done_evt = v[2]; mon_evt = v[3];
      gen_evt = {v[5], v[4]}; sigq_nonempty = v[6]; sync_state = v[7];
      miss_evt = v[8]; detail_rd = v[9];
      #1;
      if (v[0]) cmp8("R4 pre-clear value", rd_data, exp_q);
      acc   = v[8] & ~e_lock;
      nx[7] = (exp_q[7] & ~v[0]) | v[1];
      nx[6] = v[6];
      nx[5] = (exp_q[5] & ~v[0]) | v[2];
      nx[4] = (exp_q[4] & ~v[0]) | v[3];
      nx[3] = (exp_q[3] & ~v[0]) | (v[7] ^ e_prev);
      nx[2] = (exp_q[2] & ~v[0]) | acc;
      nx[1] = (exp_q[1] & ~v[0]) | v[5];
      nx[0] = (exp_q[0] & ~v[0]) | v[4];
      e_lock = (e_lock & ~v[9]) | acc;
      e_prev = v[7];
      @(posedge clk);
      exp_q = nx;
      @(negedge clk);
      for (int b = 0; b < 8; b++) begin
         nchk++;
         if (rd_data[b] !== exp_q[b]) begin
            nerr++;
            $display("FAIL %s bit %0d: got %0b expected %0b", tag_of(b), b, rd_data[b], exp_q[b]);
         end
      end
      cmp1("R10 irq", irq, |exp_q);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   initial begin
      #(2_000_000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp8("R1 reset value", rd_data, 8'h00);
      cmp1("R1 irq at reset", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp8("R1 after release", rd_data, 8'h00);

      // R2 layout: single sources land at fixed positions
      step(10'h002); cmp8("R2 timer at bit 7", rd_data, 8'h80);
      step(10'h001);
      step(10'h020); cmp8("R2 generic 1 at bit 1", rd_data, 8'h02);
      step(10'h001);
      step(10'h100); cmp8("R2 mismatch at bit 2", rd_data, 8'h04);
      step(10'h201);  // read clears, detail read releases the lock
      cmp8("R2 cleared", rd_data, 8'h00);

      // R5: event together with read survives
      step(10'h004);
      step(10'h005); cmp1("R5 command bit kept", rd_data[5], 1'b1);
      step(10'h001); cmp1("R4 command bit cleared", rd_data[5], 1'b0);

      // R6: queue level is unaffected by reads
      step(10'h040);
      step(10'h041); cmp1("R6 level survives read", rd_data[6], 1'b1);
      step(10'h000); cmp1("R6 follows empty", rd_data[6], 1'b0);

      // R7: both directions of the sync flag
      step(10'h080); cmp1("R7 rising change", rd_data[3], 1'b1);
      step(10'h081); cmp1("R7 cleared while steady", rd_data[3], 1'b0);
      step(10'h000); cmp1("R7 falling change", rd_data[3], 1'b1);
      step(10'h001);

      // R8 / R9: lockout sequence
      step(10'h100); cmp1("R8 first mismatch", rd_data[2], 1'b1);
      step(10'h001); cmp1("R8 cleared by read", rd_data[2], 1'b0);
      step(10'h100); cmp1("R8 locked mismatch ignored", rd_data[2], 1'b0);
      step(10'h300); cmp1("R9 mismatch with releasing read ignored", rd_data[2], 1'b0);
      step(10'h100); cmp1("R9 mismatch accepted after release", rd_data[2], 1'b1);
      step(10'h201);

      // near-exhaustive sweep over the ten inputs, two orderings
      for (int i = 0; i < 1024; i++) step(i[9:0]);
      for (int i = 0; i < 1024; i++) step(10'((i * 613 + 101) % 1024));

      done = 1'b1;
      summary();
      $finish;
   end
endmodule